// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Sequencing

This block keeps an asynchronous DRAM refreshed using CAS-before-RAS cycles, in which the device picks the row from its own counter, so no address is driven. After reset it waits out a power-up pause and then asks for a burst of wake-up refresh cycles. Only after those has it signalled that normal accesses may begin. From then on it owes one refresh every fixed interval and asks for the bus whenever a refresh is owed.

The access controller answers the request with a grant once its own page cycle has ended and RAS is high. The scheduler then drives the strobes through a full refresh cycle on its own. A short all-high lead gives the RAS-precharge-to-CAS hold. Both CAS lines then fall before RAS, CAS is held low for a while after RAS falls, and RAS stays low for a bounded time before a closing precharge. Intervals that pass without a grant are counted as owed refreshes, up to a small cap. WE is held inactive throughout.

All timings are given in clock cycles as parameters. The defaults assume a 10 ns clock: a 100 µs pause and a 15.6 µs interval.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is held, and in the first cycle after it, ref_req and init_done are low and ras_n, ucas_n, lcas_n and we_n are high.
- R2: ref_req stays low for the first PAUSE_CYC clock edges after reset release and is high after exactly PAUSE_CYC edges.
- R3: init_done rises only after exactly INIT_CYC refresh cycles have completed since reset, and once high it stays high.
- R4: After init_done, the owed-refresh count rises by one every INTERVAL_CYC cycles and saturates at PEND_MAX.
- R5: ref_req is high exactly when a refresh is owed and no refresh cycle is running, and it stays high until a grant is sampled. A refresh cycle starts on the clock edge where ref_req and ref_gnt are both high.
- R6: A refresh cycle lasts LEAD_CYC cycles with all strobes high, then CSR_CYC cycles with both CAS low and RAS high, then RAS_CYC cycles with RAS low (CAS low only in the first CHR_CYC of them), then RP_CYC cycles with all strobes high. RAS never falls unless CAS was already low in the previous cycle.
- R7: we_n is high in every cycle, and ucas_n always equals lcas_n.
- R8: ras_n is never low for more than RAS_CYC consecutive cycles.
- R9: Each completed refresh cycle first reduces the remaining wake-up count. Once that count is zero, it retires one owed refresh instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Bus grant from the access controller, given only while RAS is high |
| ref_req | output | 1 | Refresh request to the access controller |
| init_done | output | 1 | Pause and wake-up refreshes finished; normal accesses allowed |
| ras_n | output | 1 | Row strobe during refresh, active low |
| ucas_n | output | 1 | Upper column strobe during refresh, active low |
| lcas_n | output | 1 | Lower column strobe during refresh, active low |
| we_n | output | 1 | Write enable, held inactive high |

## Verification
The embedded assertions check, in every cycle, the timing rules that hold locally:
- CAS is low before RAS falls.
- The RAS-low run never exceeds its bound.
- WE stays inactive and the two CAS lines match.
- No request appears during the pause.
- An ungranted request is held.
- init_done never falls.

Which cycle a request appears in, the count of exactly eight wake-up cycles, and saturation of the owed-refresh count while the grant is withheld all depend on long histories. Only the bench's scenarios can show these. The bench compares each cycle against a behavioural model under three grant patterns: immediate, withheld, and sparse.

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int PAUSE_CYC    = 10000,
  parameter int INIT_CYC     = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int PEND_MAX     = 4,
  parameter int LEAD_CYC     = 1,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_CYC      = 6,
  parameter int RP_CYC       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic init_done,
  output logic ras_n,
  output logic ucas_n,
  output logic lcas_n,
  output logic we_n
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam int TW = $clog2(INTERVAL_CYC);
  localparam int QW = $clog2(PEND_MAX + 1);
  localparam int SW = $clog2(LEAD_CYC + CSR_CYC + RAS_CYC + RP_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_CSR, S_RAS, S_PRE} phase_e;

  phase_e          state;
  logic [SW-1:0]   cnt, lim;
  logic [PW-1:0]   pcnt;
  logic [IW-1:0]   init_left;
  logic [TW-1:0]   tcnt;
  logic [QW-1:0]   pend;
  logic            pause_done, need, start, last, done, tick, use_pend;

  assign pause_done = (pcnt == PW'(PAUSE_CYC));
  assign need       = pause_done && (init_left != '0 || pend != '0);
  assign ref_req    = need && (state == S_IDLE);
  assign start      = ref_req && ref_gnt;
  assign init_done  = pause_done && (init_left == '0);
  assign tick       = init_done && (tcnt == TW'(INTERVAL_CYC - 1));
  assign last       = (cnt == lim);
  assign done       = (state == S_PRE) && last;
  assign use_pend   = done && (init_left == '0);

  always_comb begin
    case (state)
      S_LEAD:  lim = SW'(LEAD_CYC - 1);
      S_CSR:   lim = SW'(CSR_CYC - 1);
      S_RAS:   lim = SW'(RAS_CYC - 1);
      default: lim = SW'(RP_CYC - 1);
    endcase
  end

  assign ras_n  = (state != S_RAS);
  assign ucas_n = !((state == S_CSR) || (state == S_RAS && cnt < SW'(CHR_CYC)));
  assign lcas_n = ucas_n;
  assign we_n   = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin state <= S_LEAD; cnt <= '0; end
        S_LEAD: if (last) begin state <= S_CSR; cnt <= '0; end else cnt <= cnt + 1'b1;
        S_CSR:  if (last) begin state <= S_RAS; cnt <= '0; end else cnt <= cnt + 1'b1;
        S_RAS:  if (last) begin state <= S_PRE; cnt <= '0; end else cnt <= cnt + 1'b1;
        S_PRE:  if (last) begin state <= S_IDLE; cnt <= '0; end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt      <= '0;
      init_left <= IW'(INIT_CYC);
      tcnt      <= '0;
      pend      <= '0;
    end else begin
      if (!pause_done) pcnt <= pcnt + 1'b1;
      if (done && init_left != '0) init_left <= init_left - 1'b1;
      if (init_done) tcnt <= tick ? '0 : tcnt + 1'b1;
      if (tick && !use_pend && pend != QW'(PEND_MAX)) pend <= pend + 1'b1;
      else if (!tick && use_pend) pend <= pend - 1'b1;
    end
  end

  logic [SW-1:0] rlow;
  always_ff @(posedge clk) begin
    if (!rst_n) rlow <= '0;
    else if (!ras_n) rlow <= rlow + 1'b1;
    else rlow <= '0;
  end

  a_r8_ras_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rlow <= SW'(RAS_CYC));
  a_r6_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!ucas_n && $past(!ucas_n)));
  a_r7_we_and_cas_pair: assert property (@(posedge clk) disable iff (!rst_n)
    we_n && (ucas_n == lcas_n));
  a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> !ref_req);
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);
  a_r3_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

// File: tb/tb_cbr_refresh_sched.sv
module tb_cbr_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE = 20, INIT = 8, INTV = 30, PMAX = 3;
  localparam int LEAD = 1, CSR = 1, CHR = 2, RAS = 6, RP = 4;
  localparam int TOTAL = LEAD + CSR + RAS + RP;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0;
  logic ref_req, init_done, ras_n, ucas_n, lcas_n, we_n;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbr_refresh_sched #(.PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .INTERVAL_CYC(INTV),
    .PEND_MAX(PMAX), .LEAD_CYC(LEAD), .CSR_CYC(CSR), .CHR_CYC(CHR),
    .RAS_CYC(RAS), .RP_CYC(RP)) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(ref_req),
    .init_done(init_done), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n));

  // behavioural model
  int m_pause, m_init, m_pend, m_tmr, m_pos;
  function automatic bit e_pdone(); return m_pause >= PAUSE; endfunction
  function automatic bit e_idone(); return e_pdone() && m_init == 0; endfunction
  function automatic bit e_req(); return e_pdone() && (m_init > 0 || m_pend > 0) && m_pos < 0; endfunction
  function automatic bit e_ras(); return !(m_pos >= LEAD + CSR && m_pos < LEAD + CSR + RAS); endfunction
  function automatic bit e_cas();
    if (m_pos >= LEAD && m_pos < LEAD + CSR) return 1'b0;
    if (m_pos >= LEAD + CSR && m_pos < LEAD + CSR + CHR) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pause = 0; m_init = INIT; m_pend = 0; m_tmr = 0; m_pos = -1;
    end else begin
      bit st, dn, tk, idn;
      int np;
      st  = e_req() && gnt;
      dn  = (m_pos == TOTAL - 1);
      idn = e_idone();
      tk  = idn && (m_tmr == INTV - 1);
      np  = m_pend + (tk ? 1 : 0);
      if (dn) begin
        if (m_init > 0) m_init--; else np--;
      end
      m_pend = (np > PMAX) ? PMAX : np;
      if (m_pause < PAUSE) m_pause++;
      if (idn) m_tmr = (m_tmr == INTV - 1) ? 0 : m_tmr + 1;
      if (st) m_pos = 0;
      else if (m_pos >= 0) m_pos = dn ? -1 : m_pos + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  bit cmp_on = 0, idone_seen = 0;
  logic prev_ras = 1'b1;
  int falls_pre_init = 0, run = 0, max_run = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(ref_req == e_req(), "R4 R5 R9 ref_req", ref_req, e_req());
      chk(init_done == e_idone(), "R3 init_done", init_done, e_idone());
      chk(ras_n == e_ras(), "R6 ras_n", ras_n, e_ras());
      chk(ucas_n == e_cas(), "R6 ucas_n", ucas_n, e_cas());
      chk(we_n == 1'b1 && lcas_n == ucas_n, "R7 we_n/lcas_n", {we_n, lcas_n}, {1'b1, ucas_n});
      if (prev_ras && !ras_n && !init_done) falls_pre_init++;
      if (!idone_seen && init_done) begin
        idone_seen = 1;
        chk(falls_pre_init == INIT, "R3 wake-up count", falls_pre_init, INIT);
      end
      run = ras_n ? 0 : run + 1;
      if (run > max_run) max_run = run;
      prev_ras = ras_n;
    end
  end

  task automatic step(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      case (mode)
        0: gnt = 1'b1;
        1: gnt = 1'b0;
        default: gnt = (cyc % 7 == 0);
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ref_req && !init_done, "R1 reset req/init", {ref_req, init_done}, 0);
    chk(ras_n && ucas_n && lcas_n && we_n, "R1 reset strobes", {ras_n, ucas_n, lcas_n, we_n}, 15);
    rst_n = 1'b1;
    cmp_on = 1;
    gnt = 1'b1;
    while (!ref_req && cyc < 1000) step(1, 0);
    chk(cyc == PAUSE, "R2 pause length", cyc, PAUSE);
    step(300, 0);
    chk(idone_seen, "R3 init reached", idone_seen, 1);
    step(INTV * (PMAX + 4), 1);
    step(200, 0);
    step(400, 2);
    step(INTV * 2 + 5, 1);
    step(300, 2);
    step(200, 0);
    chk(max_run == RAS, "R8 longest RAS-low run", max_run, RAS);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule